// File: doc/BRIEF.md
# Partial Reconfiguration Control Engine

This block is the register front end of a partial-reconfiguration engine. Software talks to it through a small 64-bit register bus. It resets the engine with a request/acknowledge handshake, then opens a session by naming a target region and setting a start bit. While the session is open it streams 32-bit bitstream words into an internal queue. When all words are pushed it sets a completion bit, and waits until hardware clears the start bit.

Software reads the free queue slots as credits in the status word, so it never has to overrun the queue. The queue empties toward a downstream consumer at a fixed rate of one word every `DRAIN_DIV` cycles. Faults are latched in a sticky error register that software clears by writing ones. The faults are misuse of the push protocol, pushing into a full queue, starting during reset, naming a region that does not exist, and a consumer-reported integrity error. A header word and two interface identifier words are read-only constants.

Top module: `rc_engine`

## Requirements
- R1: Writing 1 to control bit 0 registers a reset request. Control bit 4 (acknowledge) reads 1 from the cycle after the request reads 1. It returns to 0 one cycle after the request is written back to 0.
- R2: While the reset request is held, the queue is emptied, credits return to `DEPTH` and any open session is dropped. Latched error bits are kept.
- R3: Status bits 8:0 read `DEPTH` minus the number of stored words. Each accepted data write (offset 0x18, payload in bits 31:0) stores one word.
- R4: When the timer that wraps every `DRAIN_DIV` cycles wraps and the queue holds a word, the oldest word appears on `cfg_word` with `cfg_valid` high for one cycle. Words leave in the order they were accepted.
- R5: A control write with bit 12 set opens a session in the idle state; bits 9:7 give the region. Bit 12 reads 1 while the session is open. A control write with bit 13 set marks completion, and bit 13 then reads 1. Once the queue is empty, hardware clears both bits.
- R6: A data write outside an open, not-yet-completed session sets error bit 3 and is dropped. A completion write while no session is open also sets error bit 3.
- R7: A data write into a full queue sets error bit 4 and is dropped.
- R8: The error register (offset 0x20) clears each bit written as 1. An error event in the same cycle wins over the clear.
- R9: Status bit 16 reads 1 when a session is open, a reset is requested, or any error bit is set, and 0 otherwise. Bits 22:20 read 0 idle, 1 running, 2 draining, 3 reset requested. Bits 27:24 read, from bit 24 upward: queue full, queue empty, reset acknowledge, any error.
- R10: Offset 0x00 reads `HDR_VALUE`, 0xA8 reads `ID_LO`, 0xB0 reads `ID_HI`, and any unmapped offset reads 0.
- R11: A start request written while the reset request is held sets error bit 0. A start naming a region at or above `NUM_REGIONS` sets error bit 2 and leaves the engine idle. A high `cfg_error` sets error bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| cfg_valid | output | 1 | One-cycle pulse: a drained word is on `cfg_word` |
| cfg_word | output | 32 | Drained bitstream word |
| cfg_error | input | 1 | Consumer-side integrity error |

## Verification
The bench fills the queue faster than it drains, so it reaches the full boundary. A design with an off-by-one in the full test would either accept a word it has no room for or set the overflow bit early. It times the release of the start bit against the drain of the last word; releasing on completion alone would clear bit 12 while words still sit in the queue. It raises a consumer error in the same cycle as a write-one-to-clear, where a design that gives the clear priority loses the new fault. It also asserts reset in the middle of a session and checks that credits come back while the old protocol error stays set.

// File: rtl/rc_pkg.sv
// Shared definitions of the reconfiguration control engine: register offsets,
// bit positions that software and the decode logic agree on, session states.
package rc_pkg;

    typedef enum logic [1:0] {
        SES_IDLE  = 2'd0,
        SES_RUN   = 2'd1,
        SES_DRAIN = 2'd2
    } ses_t;

    localparam logic [7:0] OFS_HDR  = 8'h00;
    localparam logic [7:0] OFS_CTL  = 8'h08;
    localparam logic [7:0] OFS_STS  = 8'h10;
    localparam logic [7:0] OFS_DAT  = 8'h18;
    localparam logic [7:0] OFS_ERR  = 8'h20;
    localparam logic [7:0] OFS_IDLO = 8'hA8;
    localparam logic [7:0] OFS_IDHI = 8'hB0;

    localparam int CTL_RST  = 0;
    localparam int CTL_ACK  = 4;
    localparam int CTL_RGN  = 7;
    localparam int CTL_GO   = 12;
    localparam int CTL_FIN  = 13;

    localparam int ERR_OP   = 0;
    localparam int ERR_CRC  = 1;
    localparam int ERR_IMG  = 2;
    localparam int ERR_PROTO = 3;
    localparam int ERR_OVF  = 4;
    localparam int ERR_W    = 5;

    localparam int FILL_W   = 9;

endpackage

// File: rtl/rc_word_queue.sv
// Bitstream word queue with a fixed-rate drain.
// Stores up to DEPTH 32-bit words, reports its fill level and pops the oldest
// word every DRAIN_DIV cycles toward the consumer port.
// Assumes: DEPTH <= 511, DRAIN_DIV >= 1; flush has priority over push and pop.
module rc_word_queue
    import rc_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DRAIN_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push_req,
    input  logic [31:0]       push_word,
    output logic [FILL_W-1:0] fill,
    output logic              full,
    output logic              empty,
    output logic              ovf_evt,
    output logic              out_valid,
    output logic [31:0]       out_word
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int TW = (DRAIN_DIV > 1) ? $clog2(DRAIN_DIV) : 1;

    logic [31:0]       mem [DEPTH];
    logic [IW-1:0]     wp, rp;
    logic [FILL_W-1:0] cnt;
    logic [TW-1:0]     tmr;
    logic              tick, push, pop;

    assign full    = (cnt == FILL_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign fill    = cnt;
    assign tick    = (tmr == TW'(DRAIN_DIV - 1));
    assign push    = push_req && !full && !flush;
    assign pop     = tick && !empty && !flush;
    assign ovf_evt = push_req && full;

    // Free-running drain timer, wraps every DRAIN_DIV cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    tmr <= '0;
        else if (tick) tmr <= '0;
        else           tmr <= tmr + 1'b1;
    end

    // Pointer and fill bookkeeping; flush empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == IW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == IW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + FILL_W'(push) - FILL_W'(pop);
        end
    end

    // Word storage, no reset needed.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_word;
    end

    // Registered consumer port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= pop;
            if (pop) out_word <= mem[rp];
        end
    end

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FILL_W'(DEPTH));

    assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));

    generate
        if (DRAIN_DIV > 1) begin : g_rate
            assert_drain_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |=> !out_valid);
        end
    endgenerate

endmodule

// File: rtl/rc_session.sv
// Session and error control of the reconfiguration engine.
// Runs the reset request/acknowledge handshake, the idle/run/drain session
// sequence, and the sticky write-one-to-clear error register.
// Assumes: strobes are single-cycle decoded register writes from the top.
module rc_session
    import rc_pkg::*;
#(
    parameter int NUM_REGIONS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_rst,
    input  logic             ctl_go,
    input  logic             ctl_fin,
    input  logic [2:0]       ctl_rgn,
    input  logic             err_wr,
    input  logic [ERR_W-1:0] err_clr,
    input  logic             data_wr,
    input  logic             q_empty,
    input  logic             q_ovf,
    input  logic             cons_err,
    output ses_t             state,
    output logic             rst_req,
    output logic             rst_ack,
    output logic [2:0]       region,
    output logic [ERR_W-1:0] err
);
    logic             go, fin, bad_rgn;
    logic [ERR_W-1:0] set_evt, clr_mask;
    ses_t             nxt;

    assign go       = ctl_wr && ctl_go;
    assign fin      = ctl_wr && ctl_fin;
    assign bad_rgn  = (32'(ctl_rgn) >= NUM_REGIONS);
    assign clr_mask = err_wr ? err_clr : '0;

    // Collect the error events of this cycle.
    always_comb begin
        set_evt            = '0;
        set_evt[ERR_OP]    = go && rst_req;
        set_evt[ERR_CRC]   = cons_err;
        set_evt[ERR_IMG]   = go && !rst_req && (state == SES_IDLE) && bad_rgn;
        set_evt[ERR_PROTO] = (data_wr && (state != SES_RUN)) || (fin && (state == SES_IDLE));
        set_evt[ERR_OVF]   = q_ovf;
    end

    // Session sequencing; a reset request forces idle.
    always_comb begin
        nxt = state;
        if (rst_req) nxt = SES_IDLE;
        else begin
            case (state)
                SES_IDLE:  if (go && !bad_rgn) nxt = SES_RUN;
                SES_RUN:   if (fin)            nxt = SES_DRAIN;
                SES_DRAIN: if (q_empty)        nxt = SES_IDLE;
                default:                       nxt = SES_IDLE;
            endcase
        end
    end

    // State, handshake, region and sticky error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SES_IDLE;
            rst_req <= 1'b0;
            rst_ack <= 1'b0;
            region  <= '0;
            err     <= '0;
        end else begin
            state   <= nxt;
            rst_ack <= rst_req;
            if (ctl_wr) begin
                rst_req <= ctl_rst;
                region  <= ctl_rgn;
            end
            err <= (err & ~clr_mask) | set_evt;
        end
    end

    assert_ack_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_ack) |-> $past(rst_req));

    assert_reset_drops_session_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (state == SES_IDLE));

    assert_hold_until_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SES_DRAIN && !rst_req && !q_empty) |=> (state == SES_DRAIN));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !err_wr |=> ((err & $past(err)) == $past(err)));

endmodule

// File: rtl/rc_engine.sv
// Top of the reconfiguration control engine.
// Decodes register writes, routes data words into the queue under session
// control and builds the combinational read word for the addressed register.
// Assumes: bus_rdata is valid for the current bus_addr in the same cycle.
module rc_engine
    import rc_pkg::*;
#(
    parameter int          DEPTH       = 16,
    parameter int          DRAIN_DIV   = 4,
    parameter int          NUM_REGIONS = 4,
    parameter logic [63:0] HDR_VALUE   = 64'h3000_0000_1000_0005,
    parameter logic [63:0] ID_LO       = 64'h0123_4567_89AB_CDEF,
    parameter logic [63:0] ID_HI       = 64'hFEDC_BA98_7654_3210
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [63:0] bus_wdata,
    output logic [63:0] bus_rdata,
    output logic        cfg_valid,
    output logic [31:0] cfg_word,
    input  logic        cfg_error
);
    logic              ctl_wr, err_wr, data_wr, push_req;
    logic [FILL_W-1:0] fill, credits;
    logic              full, empty, ovf_evt;
    ses_t              state;
    logic              rst_req, rst_ack, busy;
    logic [2:0]        region, code;
    logic [ERR_W-1:0]  err;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign ctl_wr   = bus_wr && (bus_addr == OFS_CTL);
    assign err_wr   = bus_wr && (bus_addr == OFS_ERR);
    assign data_wr  = bus_wr && (bus_addr == OFS_DAT);
    assign push_req = data_wr && (state == SES_RUN);

    rc_session #(.NUM_REGIONS(NUM_REGIONS)) u_ses (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_rst(bus_wdata[CTL_RST]), .ctl_go(bus_wdata[CTL_GO]),
        .ctl_fin(bus_wdata[CTL_FIN]), .ctl_rgn(bus_wdata[CTL_RGN+2:CTL_RGN]),
        .err_wr(err_wr), .err_clr(bus_wdata[ERR_W-1:0]),
        .data_wr(data_wr), .q_empty(empty), .q_ovf(ovf_evt), .cons_err(cfg_error),
        .state(state), .rst_req(rst_req), .rst_ack(rst_ack), .region(region), .err(err)
    );

    rc_word_queue #(.DEPTH(DEPTH), .DRAIN_DIV(DRAIN_DIV)) u_q (
        .clk(clk), .rst_n(rst_n), .flush(rst_req),
        .push_req(push_req), .push_word(bus_wdata[31:0]),
        .fill(fill), .full(full), .empty(empty), .ovf_evt(ovf_evt),
        .out_valid(cfg_valid), .out_word(cfg_word)
    );

    assign credits = FILL_W'(DEPTH) - fill;
    assign busy    = (state != SES_IDLE) || rst_req || (|err);
    assign code    = rst_req ? 3'd3 : {1'b0, state};

    // Read word of the addressed register.
    always_comb begin
        case (bus_addr)
            OFS_HDR:  bus_rdata = HDR_VALUE;
            OFS_CTL:  bus_rdata = {50'b0, state == SES_DRAIN, state != SES_IDLE,
                                   2'b0, region, 2'b0, rst_ack, 3'b0, rst_req};
            OFS_STS:  bus_rdata = {36'b0, |err, rst_ack, empty, full, 1'b0, code,
                                   3'b0, busy, 7'b0, credits};
            OFS_ERR:  bus_rdata = {59'b0, err};
            OFS_IDLO: bus_rdata = ID_LO;
            OFS_IDHI: bus_rdata = ID_HI;
            default:  bus_rdata = '0;
        endcase
    end

    assert_no_fill_outside_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state != SES_RUN) |=> (fill <= $past(fill)));

    assert_full_blocks_growth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && full) |=> (fill <= $past(fill)));

endmodule

// File: tb/rc_engine_test.sv
module rc_engine_test;
    localparam int          DEPTH = 16;
    localparam int          DIV   = 4;
    localparam int          NREG  = 4;
    localparam logic [63:0] HDR   = 64'h3000_0000_1000_0005;
    localparam logic [63:0] IDL   = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] IDH   = 64'hFEDC_BA98_7654_3210;
    localparam logic [7:0]  A_CTL = 8'h08, A_STS = 8'h10, A_DAT = 8'h18, A_ERR = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = A_STS;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        cfg_valid;
    logic [31:0] cfg_word;
    logic        cfg_error = 1'b0;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    rc_engine #(.DEPTH(DEPTH), .DRAIN_DIV(DIV), .NUM_REGIONS(NREG),
                .HDR_VALUE(HDR), .ID_LO(IDL), .ID_HI(IDH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_valid(cfg_valid),
        .cfg_word(cfg_word), .cfg_error(cfg_error)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference model.
    logic [31:0] mq[$];
    int          m_tmr, m_st;
    bit          m_req, m_ack, m_cv;
    logic [2:0]  m_rgn;
    logic [4:0]  m_err;
    logic [31:0] m_cw;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_tmr = 0; m_st = 0; m_req = 0; m_ack = 0;
            m_rgn = 0; m_err = 0; m_cv = 0; m_cw = 0;
        end else begin
            bit tick, pop, push, cw, ew, dw;
            int n, nst;
            logic [4:0] set, clr;
            n = mq.size(); tick = (m_tmr == DIV - 1);
            cw = bus_wr && bus_addr == A_CTL; ew = bus_wr && bus_addr == A_ERR;
            dw = bus_wr && bus_addr == A_DAT;
            pop = tick && n > 0 && !m_req;
            push = dw && m_st == 1 && n < DEPTH && !m_req;
            set = 0;
            if (cfg_error) set[1] = 1;
            if (dw && m_st != 1) set[3] = 1;
            if (dw && m_st == 1 && n == DEPTH) set[4] = 1;
            if (cw && bus_wdata[12] && m_req) set[0] = 1;
            if (cw && bus_wdata[12] && !m_req && m_st == 0 && int'(bus_wdata[9:7]) >= NREG) set[2] = 1;
            if (cw && bus_wdata[13] && m_st == 0) set[3] = 1;
            nst = m_st;
            if (m_req) nst = 0;
            else if (m_st == 0 && cw && bus_wdata[12] && int'(bus_wdata[9:7]) < NREG) nst = 1;
            else if (m_st == 1 && cw && bus_wdata[13]) nst = 2;
            else if (m_st == 2 && n == 0) nst = 0;
            clr = ew ? bus_wdata[4:0] : 5'b0;
            m_err = (m_err & ~clr) | set;
            m_st = nst;
            m_ack = m_req;
            if (cw) begin m_req = bus_wdata[0]; m_rgn = bus_wdata[9:7]; end
            if (m_ack && !m_req && n >= 0) begin end
            if (tick) m_tmr = 0; else m_tmr++;
            m_cv = pop;
            if (!m_ack) begin
                if (pop) m_cw = mq.pop_front();
                if (push) mq.push_back(bus_wdata[31:0]);
            end else mq.delete();
        end
    end
    // m_ack equals the pre-edge request after the update above, so it marks flush.

    function automatic logic [63:0] exp_read(input logic [7:0] a);
        logic [63:0] r = '0;
        int n = mq.size();
        case (a)
            8'h00: r = HDR;
            A_CTL: begin r[0] = m_req; r[4] = m_ack; r[9:7] = m_rgn;
                         r[12] = (m_st != 0); r[13] = (m_st == 2); end
            A_STS: begin r[8:0] = 9'(DEPTH - n); r[16] = (m_st != 0) || m_req || (m_err != 0);
                         r[22:20] = m_req ? 3'd3 : 3'(m_st); r[24] = (n == DEPTH);
                         r[25] = (n == 0); r[26] = m_ack; r[27] = (m_err != 0); end
            A_ERR: r[4:0] = m_err;
            8'hA8: r = IDL;
            8'hB0: r = IDH;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(posedge clk) begin
        cyc++;
        #2;
        if (rst_n && !done) begin
            logic [63:0] e;
            string tag;
            e = exp_read(bus_addr);
            tag = (bus_addr == A_STS) ? "R3/R9 status" : (bus_addr == A_CTL) ? "R1/R5 control" :
                  (bus_addr == A_ERR) ? "R8 error" : "R10 constant";
            check(bus_rdata === e, tag, bus_rdata, e);
            check(cfg_valid === m_cv, "R4 cfg_valid", 64'(cfg_valid), 64'(m_cv));
            if (m_cv) check(cfg_word === m_cw, "R4 cfg_word order", 64'(cfg_word), 64'(m_cw));
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            summary();
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_addr = A_STS; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [63:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, tag, bus_rdata, exp);
        bus_addr = A_STS;
    endtask

    task automatic rdmask(input logic [7:0] a, input logic [63:0] m, input logic [63:0] exp, input string tag);
        bus_addr = a;
        #1;
        check((bus_rdata & m) === exp, tag, bus_rdata & m, exp);
        bus_addr = A_STS;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // Reset values and constants.
        rd(A_STS, 64'h0200_0010, "R3 R9 status after reset");
        rd(A_CTL, 64'h0, "R1 control after reset");
        rd(8'h00, HDR, "R10 header");
        rd(8'hA8, IDL, "R10 id low");
        rd(8'hB0, IDH, "R10 id high");
        rd(8'h40, 64'h0, "R10 unmapped");
        // Data write with no session.
        wr(A_DAT, 64'h1234);
        rd(A_ERR, 64'h8, "R6 protocol error on idle push");
        rdmask(A_STS, 64'h1_0000, 64'h1_0000, "R9 busy when error latched");
        wr(A_ERR, 64'h8);
        rd(A_ERR, 64'h0, "R8 write-one clears");
        // Reset handshake.
        wr(A_CTL, 64'h1);
        rd(A_CTL, 64'h1, "R1 request registered, no ack yet");
        idle(1);
        rd(A_CTL, 64'h11, "R1 ack follows request");
        wr(A_CTL, 64'h10);
        rd(A_CTL, 64'h10, "R1 ack still high one cycle");
        idle(1);
        rd(A_CTL, 64'h0, "R1 ack released");
        rdmask(A_STS, 64'h1_0000, 64'h0, "R9 idle after handshake");
        // Session with overflow.
        wr(A_CTL, 64'h1080);
        rd(A_CTL, 64'h1080, "R5 start bit reads set");
        rdmask(A_STS, 64'h71_0000, 64'h11_0000, "R9 running code");
        for (int i = 0; i < 26; i++) wr(A_DAT, 64'hFFFF_0000_A000_0000 + 64'(i));
        rdmask(A_ERR, 64'h10, 64'h10, "R7 overflow latched");
        rdmask(A_ERR, 64'h8, 64'h0, "R6 no protocol error in session");
        wr(A_CTL, 64'h3080);
        rdmask(A_CTL, 64'h3000, 64'h3000, "R5 completion reads set while draining");
        idle(90);
        rd(A_CTL, 64'h0080, "R5 hardware released start and completion");
        rdmask(A_STS, 64'h1FF, 64'(DEPTH), "R3 credits restored after drain");
        wr(A_ERR, 64'h1F);
        rdmask(A_STS, 64'h1_0000, 64'h0, "R9 idle after clear");
        // Start during reset.
        wr(A_CTL, 64'h1);
        idle(1);
        wr(A_CTL, 64'h1001);
        wr(A_CTL, 64'h0);
        idle(2);
        rd(A_ERR, 64'h1, "R11 operation error");
        wr(A_ERR, 64'h1);
        // Bad region.
        wr(A_CTL, 64'h1280);
        rd(A_ERR, 64'h4, "R11 incompatible region");
        rdmask(A_CTL, 64'h1000, 64'h0, "R11 stays idle on bad region");
        wr(A_ERR, 64'h4);
        // Completion with no session.
        wr(A_CTL, 64'h2000);
        rd(A_ERR, 64'h8, "R6 completion outside session");
        wr(A_ERR, 64'h8);
        // Consumer error and clear collision.
        cfg_error = 1; @(negedge clk); cfg_error = 0;
        rd(A_ERR, 64'h2, "R11 consumer error");
        cfg_error = 1; wr(A_ERR, 64'h1F); cfg_error = 0;
        rd(A_ERR, 64'h2, "R8 new event wins over clear");
        wr(A_ERR, 64'h2);
        // Reset during a session keeps errors.
        wr(A_DAT, 64'h5);
        wr(A_CTL, 64'h1100);
        for (int i = 0; i < 5; i++) wr(A_DAT, 64'hB000_0000 + 64'(i));
        wr(A_CTL, 64'h1101);
        idle(3);
        rdmask(A_STS, 64'h1FF, 64'(DEPTH), "R2 credits full under reset");
        rd(A_ERR, 64'h8, "R2 errors kept through reset");
        rdmask(A_CTL, 64'h1000, 64'h0, "R2 session dropped");
        wr(A_CTL, 64'h0);
        idle(3);
        done = 1;
        summary();
        $finish;
    end
endmodule